// File: doc/BRIEF.md
# Mixed-Sign Multiply-Add Unit

This unit multiplies a 64-bit unsigned multiplicand by a 64-bit two's-complement multiplier. It adds a 64-bit signed addend to the product and returns the full 128-bit result as a low word and a high word. A typical use is a long-integer multiply by a signed scalar. The caller feeds the high word of one result back in as the addend of the next operation, so the high word acts as a 64-bit carry between limbs.

Operands enter through a valid/ready handshake. They pass through two register stages and leave through a second valid/ready handshake. With the output side ready, the unit accepts one operation per cycle. Each result appears on the cycle after the accepting edge's successor, that is, after two clock edges. When the output is stalled, the stages fill and the input side stops accepting. The datapath by default takes the magnitude of a negative multiplier on a 65-bit path, multiplies unsigned, and negates the product. A parameter selects a direct signed multiply instead.

Top module: `mixmac_top`

## Requirements
- R1: `mcand_i` is read as an unsigned number. All-ones times 1 plus 0 gives a low word of all ones and a high word of zero.
- R2: `mplier_i` is read as two's complement. A multiplicand of 1 times all ones gives all ones in both words.
- R3: `addend_i` is sign-extended to 128 bits before the add. 0 times 0 plus all ones gives all ones in both words.
- R4: `res_lo_o` carries bits 63:0 of the 128-bit sum and `res_hi_o` carries bits 127:64.
- R5: A multiplier of -2^63 (only bit 63 set) gives the exact mixed-sign product, with no overflow of the negated magnitude.
- R6: An operation accepted at clock edge n (`in_valid_i` and `in_ready_o` both high) drives `out_valid_o` high from edge n+1, provided `out_ready_i` is high in the cycle after acceptance. With `out_ready_i` held high, one operation is accepted every cycle.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high with unchanged result words.
- R8: Every accepted operation is delivered exactly once and in order. `in_ready_o` is low only when `out_valid_o` is high and `out_ready_i` is low. At most two operations are in flight.
- R9: Asserting `rst_ni` low clears `out_valid_o` at once, discards any operation in flight, and leaves `in_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands present |
| in_ready_o | output | 1 | Unit can take operands this cycle |
| mcand_i | input | 64 | Unsigned multiplicand |
| mplier_i | input | 64 | Signed multiplier |
| addend_i | input | 64 | Signed addend |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| res_lo_o | output | 64 | Bits 63:0 of the sum |
| res_hi_o | output | 64 | Bits 127:64 of the sum |

## Verification
The hardest condition to reach from the ports is a full pipe with new operands waiting. In that state both stages hold results, the output is stalled, and the input side must hold off and keep its operands. The bench reaches it by dropping `out_ready_i` at random in about one cycle of three while the driver offers operands back to back. This repeatedly fills both stages, and the scoreboard catches any lost, doubled or reordered result.

The negated-magnitude corner is not found by chance. The bench drives multipliers of -2^63 directly, paired with all-ones multiplicands and extreme addends.

// File: rtl/mixmac_pkg.sv
package mixmac_pkg;
  parameter int unsigned OP_W = 64;
  localparam int unsigned RES_W = 2 * OP_W;
  typedef logic [OP_W-1:0]  op_t;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/mixmac_mul.sv
module mixmac_mul #(
  parameter int unsigned W        = mixmac_pkg::OP_W,
  parameter bit          NEG_PATH = 1'b1
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  generate
    if (NEG_PATH) begin : g_neg
      // magnitude needs W+1 bits: -(-2^(W-1)) = 2^(W-1)
      logic [W:0]   b_ext, b_mag;
      logic [2*W:0] mag_prod, neg_prod;
      assign b_ext    = {b_i[W-1], b_i};
      assign b_mag    = b_i[W-1] ? ((W+1)'(0) - b_ext) : b_ext;
      assign mag_prod = {{(W+1){1'b0}}, a_i} * {{W{1'b0}}, b_mag};
      assign neg_prod = (2*W+1)'(0) - mag_prod;
      assign p_o      = b_i[W-1] ? neg_prod[2*W-1:0] : mag_prod[2*W-1:0];
    end else begin : g_dir
      logic signed [2*W:0] sprod;
      assign sprod = $signed({{(W+1){1'b0}}, a_i}) * $signed({{(W+1){b_i[W-1]}}, b_i});
      assign p_o   = sprod[2*W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mixmac_stage.sv
module mixmac_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_valid_i,
  output logic          up_ready_o,
  input  logic [DW-1:0] up_data_i,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic [DW-1:0] dn_data_o
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign up_ready_o = !vld_q || dn_ready_i;
  assign dn_valid_o = vld_q;
  assign dn_data_o  = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vld_q <= 1'b0;
    else if (up_ready_o) vld_q <= up_valid_i;
  end

  // data needs no reset: qualified by vld_q
  always_ff @(posedge clk_i) begin
    if (up_ready_o && up_valid_i) dat_q <= up_data_i;
  end
endmodule

// File: rtl/mixmac_top.sv
module mixmac_top
  import mixmac_pkg::*;
#(
  parameter bit NEG_PATH = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [OP_W-1:0] mcand_i,
  input  logic [OP_W-1:0] mplier_i,
  input  logic [OP_W-1:0] addend_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [OP_W-1:0] res_lo_o,
  output logic [OP_W-1:0] res_hi_o
);
  localparam int unsigned S1_W = RES_W + OP_W;

  res_t            prod;
  logic [S1_W-1:0] s1_data;
  logic            s1_valid, s2_ready;
  res_t            sum;
  res_t            s2_data;

  mixmac_mul #(.W(OP_W), .NEG_PATH(NEG_PATH)) u_mul (
    .a_i (mcand_i),
    .b_i (mplier_i),
    .p_o (prod)
  );

  mixmac_stage #(.DW(S1_W)) u_s1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_valid_i (in_valid_i),
    .up_ready_o (in_ready_o),
    .up_data_i  ({prod, addend_i}),
    .dn_valid_o (s1_valid),
    .dn_ready_i (s2_ready),
    .dn_data_o  (s1_data)
  );

  op_t s1_add;
  assign s1_add = s1_data[OP_W-1:0];
  assign sum    = s1_data[S1_W-1:OP_W] + {{OP_W{s1_add[OP_W-1]}}, s1_add};

  mixmac_stage #(.DW(RES_W)) u_s2 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_valid_i (s1_valid),
    .up_ready_o (s2_ready),
    .up_data_i  (sum),
    .dn_valid_o (out_valid_o),
    .dn_ready_i (out_ready_i),
    .dn_data_o  (s2_data)
  );

  assign res_lo_o = s2_data[OP_W-1:0];
  assign res_hi_o = s2_data[RES_W-1:OP_W];
endmodule

// File: rtl/mixmac_chk.sv
module mixmac_chk
  import mixmac_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [OP_W-1:0] mcand_i,
  input logic [OP_W-1:0] mplier_i,
  input logic [OP_W-1:0] addend_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [OP_W-1:0] res_lo_o,
  input logic [OP_W-1:0] res_hi_o
);
  logic       in_fire, out_fire;
  logic [2:0] occ_q;
  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + 3'(in_fire) - 3'(out_fire);
  end

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_fire) && out_ready_i) |=> out_valid_o);

  p_hold_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_lo_o) && $stable(res_hi_o)));

  p_backpress_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (out_valid_o && !out_ready_i));

  p_inflight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= 3'd2);

  p_reset_clear_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && in_ready_o));
endmodule

bind mixmac_top mixmac_chk u_chk (.*);

// File: tb/sim_mixmac_top.sv
module sim_mixmac_top;
  localparam int W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         in_valid_i, in_ready_o, out_valid_o, out_ready_i;
  logic [W-1:0] mcand_i, mplier_i, addend_i, res_lo_o, res_hi_o;

  always #5 clk_i = ~clk_i;

  mixmac_top u0 (.*);

  typedef struct {
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    int           acc;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           n_chk = 0, n_fail = 0, cyc = 0, n_sent = 0, n_got = 0;
  bit           lat_mode = 1'b0, done = 1'b0;
  int           rdy_mode = 0;
  bit           hold_pend = 1'b0;
  logic [W-1:0] hold_lo, hold_hi;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a, b, c);
    logic signed [2*W:0] p;
    p = $signed({{(W+1){1'b0}}, a}) * $signed({{(W+1){b[W-1]}}, b});
    return p[2*W-1:0] + {{W{c[W-1]}}, c};
  endfunction

  // called at posedge+2; returns at posedge+2 after the accepting edge
  task automatic send(input logic [W-1:0] a, b, c, input string tag);
    bit           rdy;
    logic [2*W-1:0] e;
    in_valid_i = 1'b1; mcand_i = a; mplier_i = b; addend_i = c;
    do begin
      @(negedge clk_i); rdy = in_ready_o;
      @(posedge clk_i);
    end while (!rdy);
    #2;
    e = model(a, b, c);
    sb.push_back('{lo: e[W-1:0], hi: e[2*W-1:W], acc: cyc, tag: tag});
    n_sent++;
  endtask

  task automatic idle();
    in_valid_i = 1'b0;
  endtask

  // output-side ready pattern
  always @(posedge clk_i) begin
    #2;
    case (rdy_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = ($urandom % 3) != 0;
      default: out_ready_i = 1'b0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (!rst_ni) hold_pend = 1'b0;
    else begin
      if (hold_pend) // R7
        chk(out_valid_o && res_lo_o == hold_lo && res_hi_o == hold_hi, "R7 held result",
            {res_hi_o, res_lo_o}, {hold_hi, hold_lo});
      if (!in_ready_o) // R8
        chk(out_valid_o && !out_ready_i, "R8 ready only low when stalled",
            {126'd0, out_valid_o, out_ready_i}, 128'd2);
      hold_pend = out_valid_o && !out_ready_i;
      hold_lo = res_lo_o; hold_hi = res_hi_o;
      if (out_valid_o && out_ready_i) begin
        n_got++;
        if (sb.size() == 0) chk(1'b0, "R8 unexpected result", {res_hi_o, res_lo_o}, '0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_lo_o == e.lo && res_hi_o == e.hi, e.tag, {res_hi_o, res_lo_o}, {e.hi, e.lo});
          if (lat_mode)
            chk(cyc - e.acc == 1, "R6 latency", 128'(cyc - e.acc), 128'd1);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic drain();
    int k = 0;
    while (sb.size() != 0 && k < 2000) begin
      @(posedge clk_i); k++;
    end
    repeat (3) @(posedge clk_i);
    #2;
  endtask

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b1;
    mcand_i = '0; mplier_i = '0; addend_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!out_valid_o && in_ready_o, "R9 reset state", {126'd0, out_valid_o, in_ready_o}, 128'd1);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    lat_mode = 1'b1;
    send(ONES, 64'd1, 64'd0, "R1 unsigned mcand");
    send(64'd1, ONES, 64'd0, "R2 signed mplier");
    send(ONES, ONES, 64'd0, "R2 allones x minus one");
    send(64'd0, 64'd0, ONES, "R3 addend sign ext");
    send(64'd7, 64'd3, MINV, "R3 negative addend");
    send(MINV, 64'd4, 64'd5, "R4 word split");
    send(64'd3, MINV, 64'd0, "R5 min mplier");
    send(ONES, MINV, MINV, "R5 min mplier extremes");
    send(ONES, MINV, ONES, "R5 min mplier addend -1");
    for (int i = 0; i < 40; i++)
      send({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R4 random");
    idle();
    drain();
    lat_mode = 1'b0;

    rdy_mode = 1;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] b;
      b = (i % 17 == 0) ? MINV : {$urandom, $urandom};
      send({$urandom, $urandom}, b, {$urandom, $urandom}, "R8 stalled stream");
    end
    idle();
    rdy_mode = 0;
    drain();
    chk(sb.size() == 0 && n_got == n_sent, "R8 all delivered",
        128'(n_got), 128'(n_sent));

    rdy_mode = 2;
    @(posedge clk_i); #2;
    send(64'd5, 64'd6, 64'd7, "R9 flushed");
    idle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(out_valid_o, "R7 parked result", {127'd0, out_valid_o}, 128'd1);
    rst_ni = 1'b0;
    #1;
    chk(!out_valid_o && in_ready_o, "R9 async clear", {126'd0, out_valid_o, in_ready_o}, 128'd1);
    sb.delete();
    repeat (2) @(posedge clk_i);
    summary();
  end
endmodule